// File: doc/BRIEF.md
# Luma 16x16 Intra Prediction Generator

This block produces the 16x16 luma intra-prediction block used by a video encoder or decoder. The caller presents the reconstructed neighbourhood of the block in parallel: the row of 16 pixels directly above, the column of 16 pixels directly to the left, the single corner pixel above-left, and one flag for each edge that says whether that edge exists. A 2-bit mode picks one of four predictors. The first is a flat DC average of the available edges. The second copies the top row downwards. The third extends each left pixel across its row. The fourth is a gradient predictor, left plus above minus corner, with the result clamped to the pixel range.

A one-cycle `start` pulse captures the neighbours and the mode. The block then streams the prediction as 16 rows of 128 bits each, one row per accepted beat, under a valid/ready handshake. A one-cycle `done` pulse follows the last row. The controller has two states. In IDLE it waits for `start`, and `start` moves it to EMIT. In EMIT it presents row `row_q` and moves to the next row on each accepted beat. Acceptance of the final row takes it back to IDLE and raises `done` in the following cycle.

Top module: `luma16_intra_gen`

## Requirements
- R1: `mode_in` is decoded as 0 = DC, 1 = vertical, 2 = horizontal, 3 = gradient (TrueMotion).
- R2: In DC mode with both availability flags low, every output pixel is 128, whatever the neighbour values.
- R3: In DC mode with exactly one flag high, every pixel is (sum of that edge's 16 pixels + 8) >> 4.
- R4: In DC mode with both flags high, every pixel is (sum of all 32 edge pixels + 16) >> 5.
- R5: In vertical mode every output row equals the above row, column for column.
- R6: In horizontal mode every pixel of output row r equals left pixel r (left pixel r is byte r of `left_in`, with row 0 at the top).
- R7: In gradient mode pixel (r,c) is left[r] + above[c] - corner, clamped to the range 0..255.
- R8: Vertical, horizontal and gradient modes give the same output whatever the availability flags are.
- R9: Rows leave in order 0 to 15. Column c of a row sits in bits [8c+7:8c] of `row_data` (the same packing applies to `above_in` and `left_in`). A row advances only on a cycle where `row_valid` and `row_ready` are both high, and it stays unchanged while it is stalled.
- R10: Neighbours, flags and mode are captured on `start` in IDLE. Later changes to the inputs, and any `start` during EMIT, have no effect on the block being emitted.
- R11: `done` is high for exactly one cycle, in the cycle after row 15 is accepted, and `row_valid` is low in that cycle.
- R12: A synchronous active-high `rst` returns the block to IDLE with `row_valid` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture neighbours and mode, begin a block |
| mode_in | input | 2 | Prediction mode select |
| above_in | input | 128 | 16 pixels above the block, column 0 in the low byte |
| left_in | input | 128 | 16 pixels left of the block, row 0 in the low byte |
| corner_in | input | 8 | Pixel above-left of the block |
| above_ok | input | 1 | Above edge present |
| left_ok | input | 1 | Left edge present |
| row_data | output | 128 | Current prediction row, column 0 in the low byte |
| row_valid | output | 1 | Row on `row_data` is valid |
| row_ready | input | 1 | Consumer accepts the current row |
| done | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
The assertions check the handshake and sequencing properties on every cycle. They cover the reset state, the row being held while it is stalled, `done` being a single pulse that comes only after an accepted beat with `row_valid` low, and a block opening only on `start`. The arithmetic cannot be checked that way: the DC rounding for each flag combination, edge replication, gradient clamping at both ends, and the immunity of the captured block to later inputs and stray `start` pulses are only shown by the bench. It compares every emitted row with values it computes itself, under random back-pressure.

// File: rtl/luma16_pkg.sv
package luma16_pkg;

    typedef enum logic [1:0] {
        PM_DC    = 2'd0,
        PM_VERT  = 2'd1,
        PM_HORZ  = 2'd2,
        PM_TRUEM = 2'd3
    } pred_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } gen_state_e;

endpackage

// File: rtl/luma16_dc_calc.sv
module luma16_dc_calc #(
    parameter int N  = 16,
    parameter int PW = 8
) (
    input  logic [N*PW-1:0] above_flat,
    input  logic [N*PW-1:0] left_flat,
    input  logic            above_ok,
    input  logic            left_ok,
    output logic [PW-1:0]   dc_val
);
    localparam int LOGN = $clog2(N);
    localparam int SUMW = PW + LOGN + 2;

    logic [SUMW-1:0] edge_sum;
    logic [SUMW-1:0] rounded;

    always_comb begin
        edge_sum = '0;
        for (int i = 0; i < N; i++) begin
            if (above_ok) edge_sum = edge_sum + SUMW'(above_flat[i*PW +: PW]);
            if (left_ok)  edge_sum = edge_sum + SUMW'(left_flat[i*PW +: PW]);
        end
    end

    always_comb begin
        rounded = '0;
        dc_val  = PW'(1 << (PW - 1));
        unique case ({above_ok, left_ok})
            2'b11: begin
                rounded = (edge_sum + SUMW'(N)) >> (LOGN + 1);
                dc_val  = rounded[PW-1:0];
            end
            2'b10, 2'b01: begin
                rounded = (edge_sum + SUMW'(N / 2)) >> LOGN;
                dc_val  = rounded[PW-1:0];
            end
            default: dc_val = PW'(1 << (PW - 1));
        endcase
    end
endmodule

// File: rtl/luma16_row_build.sv
module luma16_row_build
    import luma16_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = 8,
    parameter int RW = $clog2(N)
) (
    input  pred_mode_e      mode,
    input  logic [RW-1:0]   row_idx,
    input  logic [N*PW-1:0] above_flat,
    input  logic [N*PW-1:0] left_flat,
    input  logic [PW-1:0]   corner,
    input  logic [PW-1:0]   dc_val,
    output logic [N*PW-1:0] row_word
);
    logic [PW-1:0] left_px;
    assign left_px = left_flat[row_idx*PW +: PW];

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [PW-1:0]        above_px;
        logic signed [PW+1:0] grad;
        logic [PW-1:0]        grad_px;

        assign above_px = above_flat[c*PW +: PW];

        always_comb begin
            grad = $signed({2'b00, left_px}) + $signed({2'b00, above_px})
                 - $signed({2'b00, corner});
            if (grad[PW+1])
                grad_px = '0;
            else if (grad[PW])
                grad_px = '1;
            else
                grad_px = grad[PW-1:0];
        end

        always_comb begin
            unique case (mode)
                PM_VERT:  row_word[c*PW +: PW] = above_px;
                PM_HORZ:  row_word[c*PW +: PW] = left_px;
                PM_TRUEM: row_word[c*PW +: PW] = grad_px;
                default:  row_word[c*PW +: PW] = dc_val;
            endcase
        end
    end
endmodule

// File: rtl/luma16_intra_gen.sv
module luma16_intra_gen
    import luma16_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      mode_in,
    input  logic [N*PW-1:0] above_in,
    input  logic [N*PW-1:0] left_in,
    input  logic [PW-1:0]   corner_in,
    input  logic            above_ok,
    input  logic            left_ok,
    output logic [N*PW-1:0] row_data,
    output logic            row_valid,
    input  logic            row_ready,
    output logic            done
);
    localparam int RW = $clog2(N);
    localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);

    gen_state_e      state_q, state_d;
    logic [RW-1:0]   row_q;
    pred_mode_e      mode_q;
    logic [N*PW-1:0] above_q, left_q;
    logic [PW-1:0]   corner_q;
    logic            aok_q, lok_q;
    logic            done_q;
    logic [PW-1:0]   dc_val;
    logic            beat;
    logic            capture;

    assign beat    = (state_q == ST_EMIT) && row_ready;
    assign capture = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EMIT;
            ST_EMIT: if (beat && row_q == LAST_ROW) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            done_q   <= 1'b0;
            mode_q   <= PM_DC;
            above_q  <= '0;
            left_q   <= '0;
            corner_q <= '0;
            aok_q    <= 1'b0;
            lok_q    <= 1'b0;
        end else begin
            done_q <= beat && (row_q == LAST_ROW);
            if (capture) begin
                row_q    <= '0;
                mode_q   <= pred_mode_e'(mode_in);
                above_q  <= above_in;
                left_q   <= left_in;
                corner_q <= corner_in;
                aok_q    <= above_ok;
                lok_q    <= left_ok;
            end else if (beat) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    luma16_dc_calc #(.N(N), .PW(PW)) dc_i (
        .above_flat (above_q),
        .left_flat  (left_q),
        .above_ok   (aok_q),
        .left_ok    (lok_q),
        .dc_val     (dc_val)
    );

    luma16_row_build #(.N(N), .PW(PW), .RW(RW)) row_i (
        .mode       (mode_q),
        .row_idx    (row_q),
        .above_flat (above_q),
        .left_flat  (left_q),
        .corner     (corner_q),
        .dc_val     (dc_val),
        .row_word   (row_data)
    );

    // outputs
    always_comb begin
        row_valid = (state_q == ST_EMIT);
        done      = done_q;
    end
endmodule

// File: rtl/luma16_intra_gen_chk.sv
module luma16_intra_gen_chk #(
    parameter int N  = 16,
    parameter int PW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [N*PW-1:0] row_data,
    input logic            row_valid,
    input logic            row_ready,
    input logic            done
);
    // R12
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!row_valid && !done));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (row_valid && !row_ready) |=> (row_valid && $stable(row_data)));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!row_valid && $past(row_valid && row_ready)));

    // R10
    open_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(row_valid) |-> $past(start));
endmodule

bind luma16_intra_gen luma16_intra_gen_chk #(.N(N), .PW(PW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .row_data  (row_data),
    .row_valid (row_valid),
    .row_ready (row_ready),
    .done      (done)
);

// File: tb/luma16_intra_gen_tb_top.sv
module luma16_intra_gen_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   mode_in = 2'd0;
    logic [127:0] above_in = '0;
    logic [127:0] left_in = '0;
    logic [7:0]   corner_in = '0;
    logic         above_ok = 1'b0;
    logic         left_ok = 1'b0;
    logic [127:0] row_data;
    logic         row_valid;
    logic         row_ready = 1'b0;
    logic         done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    luma16_intra_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in),
        .above_in(above_in), .left_in(left_in), .corner_in(corner_in),
        .above_ok(above_ok), .left_ok(left_ok), .row_data(row_data),
        .row_valid(row_valid), .row_ready(row_ready), .done(done)
    );

    function automatic int px(logic [127:0] v, int i);
        return int'(v[i*8 +: 8]);
    endfunction

    function automatic logic [127:0] exp_row(int m, logic [127:0] ab, logic [127:0] lf,
                                             int cor, bit aok, bit lok, int r);
        logic [127:0] w;
        int s, dc, t;
        s = 0;
        for (int i = 0; i < 16; i++) begin
            if (aok) s += px(ab, i);
            if (lok) s += px(lf, i);
        end
        if (aok && lok)      dc = (s + 16) / 32;
        else if (aok || lok) dc = (s + 8) / 16;
        else                 dc = 128;
        for (int c = 0; c < 16; c++) begin
            case (m)
                1: t = px(ab, c);
                2: t = px(lf, r);
                3: begin
                    t = px(lf, r) + px(ab, c) - cor;
                    if (t < 0) t = 0;
                    if (t > 255) t = 255;
                end
                default: t = dc;
            endcase
            w[c*8 +: 8] = 8'(t);
        end
        return w;
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string tag_for(int m, bit aok, bit lok);
        if (m == 1) return "R5";
        if (m == 2) return "R6";
        if (m == 3) return "R7";
        if (!aok && !lok) return "R2";
        if (aok && lok) return "R4";
        return "R3";
    endfunction

    // Run one block; stall_pct sets back-pressure, noisy scrambles inputs and pulses start
    task automatic run_block(int m, logic [127:0] ab, logic [127:0] lf, int cor,
                             bit aok, bit lok, int stall_pct, bit noisy);
        int row;
        logic [127:0] e;
        string tg;
        tg = tag_for(m, aok, lok);
        @(negedge clk);
        mode_in = 2'(m); above_in = ab; left_in = lf; corner_in = 8'(cor);
        above_ok = aok; left_ok = lok; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        row = 0;
        while (row < 16) begin
            if (noisy) begin
                above_in = {$urandom, $urandom, $urandom, $urandom};
                left_in = {$urandom, $urandom, $urandom, $urandom};
                corner_in = 8'($urandom);
                mode_in = 2'($urandom);
                above_ok = 1'($urandom); left_ok = 1'($urandom);
                start = 1'($urandom);
            end
            row_ready = ($urandom % 100) >= stall_pct;
            e = exp_row(m, ab, lf, cor, aok, lok, row);
            check(row_valid === 1'b1, "R9", {127'd0, row_valid}, 128'd1);
            // R9 row order and packing; R10 when noisy
            check(row_data === e, noisy ? "R10" : tg, row_data, e);
            if (row_ready) row++;
            @(negedge clk);
        end
        start = 1'b0;
        row_ready = 1'b0;
        // R11 done one cycle after row 15 accepted, valid low
        check(done === 1'b1 && row_valid === 1'b0, "R11", {126'd0, done, row_valid}, 128'd2);
        @(negedge clk);
        check(done === 1'b0, "R11", {127'd0, done}, 128'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] a, l;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        check(row_valid === 1'b0 && done === 1'b0, "R12", {126'd0, row_valid, done}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(row_valid === 1'b0, "R12", {127'd0, row_valid}, 128'd0);

        a = {$urandom, $urandom, $urandom, $urandom};
        l = {$urandom, $urandom, $urandom, $urandom};
        // R2 no edges: 128 regardless of data
        run_block(0, a, l, 9, 1'b0, 1'b0, 0, 1'b0);
        // R3 above only: single 16 -> (16+8)>>4 = 1
        run_block(0, 128'd16, l, 0, 1'b1, 1'b0, 30, 1'b0);
        // R3 left only, all 255
        run_block(0, a, {16{8'hFF}}, 0, 1'b0, 1'b1, 30, 1'b0);
        // R4 both: 16*1 + 16*2 = 48, (48+16)>>5 = 2
        run_block(0, {16{8'h01}}, {16{8'h02}}, 0, 1'b1, 1'b1, 0, 1'b0);
        // R5 R8 vertical with flags low
        run_block(1, a, l, 0, 1'b0, 1'b0, 20, 1'b0);
        // R6 R8 horizontal with flags low
        run_block(2, a, l, 0, 1'b0, 1'b0, 20, 1'b0);
        // R7 clamp high and low
        run_block(3, {16{8'hFF}}, {16{8'hFF}}, 0, 1'b1, 1'b1, 0, 1'b0);
        run_block(3, '0, '0, 255, 1'b0, 1'b1, 0, 1'b0);
        // R1 R10 mode decode with scrambled inputs and stray start pulses
        for (int m = 0; m < 4; m++)
            run_block(m, a, l, 77, 1'b1, 1'b0, 40, 1'b1);
        // random mix
        for (int k = 0; k < 40; k++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            l = {$urandom, $urandom, $urandom, $urandom};
            run_block(int'($urandom % 4), a, l, int'($urandom % 256),
                      1'($urandom), 1'($urandom), int'($urandom % 60), 1'($urandom));
        end

        // R12 reset mid-block
        @(negedge clk);
        mode_in = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(row_valid === 1'b0 && done === 1'b0, "R12", {126'd0, row_valid, done}, 128'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule